// File: doc/BRIEF.md
# Debug Address Breakpoint Unit

This block holds one hardware breakpoint for a small CPU core. A programmable address is compared with the CPU's bus traffic, and the block asks the core to stop and enter background debug mode. The same comparison serves two kinds of stop, and a select bit picks between them.

In forced mode, a bus access of any kind to the watched address arms a sticky flag. The stop is then requested at the next instruction boundary. In tagged mode, the comparison is made against opcode fetch addresses instead. A fetched opcode that matches carries a mark through a shadow queue, which tracks the core's instruction queue entry for entry. The request is raised only when that marked opcode is popped for execution. Flushing the queue drops every mark in it. Tagged mode is only useful at opcode addresses, while forced mode may watch any address.

While the debug port is making its own accesses, no comparison can match. The request stays raised until the core acknowledges it.

Top module: `dbg_bkpt_unit`

## Requirements
- R1: After reset, `bkpt_req` is 0 and the tag queue is empty.
- R2: While `cfg_enable` is 0, `bkpt_req` is 0 in that same cycle. An edge with `cfg_enable` at 0 also clears any armed forced flag, the request and all queued marks.
- R3: With `cfg_force_sel` = 1, an access matches when `bus_valid` is 1 and `bus_addr` equals `cfg_match`. A matching access arms the forced flag. `bkpt_req` rises in the cycle after the first `insn_boundary` that occurs in a later cycle than the access. A boundary in the same cycle as the access does not fire.
- R4: An access with `bus_valid` at 0, or with an address different from `cfg_match`, never arms the forced flag.
- R5: With `cfg_force_sel` = 0, a `fetch_push` whose `fetch_addr` equals `cfg_match` queues a marked entry. All other pushes queue unmarked entries. An `exec_pop` of a marked head entry raises `bkpt_req` in the next cycle. Popping an unmarked entry, or popping an empty queue, raises nothing.
- R6: The tag queue holds QDEPTH entries in fetch order. A pop and a push may happen in the same cycle. A push into a full queue with no pop in that cycle is dropped.
- R7: `q_flush` empties the queue and takes priority over any push or pop in the same cycle. A pop in a flush cycle raises no request.
- R8: While `dbg_access` is 1, neither bus accesses nor fetches can match.
- R9: With `bkpt_ack` at 1, the next cycle has `bkpt_req` at 0 and the forced flag clear. Any access match or boundary in that same cycle is ignored.
- R10: The select bit gates each kind of match. An access with `cfg_force_sel` = 0 never arms the forced flag. A fetch with `cfg_force_sel` = 1 is never marked.
- R11: Once raised, `bkpt_req` stays 1 until an acknowledge arrives or `cfg_enable` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_match | input | ADDR_W | Watched address |
| cfg_enable | input | 1 | Breakpoint enable |
| cfg_force_sel | input | 1 | 1 = forced, 0 = tagged |
| bus_addr | input | ADDR_W | CPU bus address |
| bus_valid | input | 1 | Bus access in this cycle |
| insn_boundary | input | 1 | Instruction boundary strobe |
| fetch_push | input | 1 | Opcode enters the instruction queue |
| fetch_addr | input | ADDR_W | Address of the fetched opcode |
| exec_pop | input | 1 | Head opcode leaves the queue for execution |
| q_flush | input | 1 | Instruction queue flush |
| dbg_access | input | 1 | Debug-port access in progress |
| bkpt_ack | input | 1 | Core acknowledges the request |
| bkpt_req | output | 1 | Breakpoint request |

## Verification
A shadow queue that is out of step with the core shows up only when a marked opcode is popped. The request then comes one pop too early, one pop too late, or not at all. The bench therefore fills the queue, pops it in runs, and flushes it at random, comparing `bkpt_req` after every edge.

A forced flag that is wrongly set or lost shows one cycle after the next boundary. Boundaries are therefore placed both in the same cycle as the access and in later cycles. An acknowledge that fails to clear state shows as a request that persists or fires again in the cycle after the acknowledge.

// File: rtl/dbg_bkpt_pkg.sv
package dbg_bkpt_pkg;
  typedef enum logic {
    KIND_TAGGED = 1'b0,
    KIND_FORCED = 1'b1
  } bkpt_kind_e;
endpackage

// File: rtl/dbg_bkpt_cmp.sv
module dbg_bkpt_cmp #(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] match_val,
  input  logic [ADDR_W-1:0] addr,
  input  logic              strobe,
  input  logic              kind_ok,
  input  logic              suppress,
  output logic              hit
);
  logic addr_eq;

  always_comb begin
    addr_eq = (addr == match_val);
    hit     = strobe && kind_ok && !suppress && addr_eq;
  end
endmodule

// File: rtl/dbg_bkpt_tagq.sv
module dbg_bkpt_tagq #(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic push,
  input  logic push_tag,
  input  logic pop,
  input  logic flush,
  output logic pop_fire
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DEPTH-1:0] tag_q, tag_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_after_pop;
  logic             do_pop, do_push, q_en;

  always_comb begin
    do_pop        = pop && (cnt_q != '0) && !flush;
    cnt_after_pop = cnt_q - CNT_W'(do_pop);
    do_push       = push && !flush && (cnt_after_pop < CNT_W'(DEPTH));
    pop_fire      = do_pop && tag_q[0];
    q_en          = clr || flush || do_pop || do_push;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic shifted;
    if (i == DEPTH - 1) begin : g_last
      assign shifted = do_pop ? 1'b0 : tag_q[i];
    end else begin : g_mid
      assign shifted = do_pop ? tag_q[i+1] : tag_q[i];
    end
    always_comb begin
      if (clr || flush)
        tag_d[i] = 1'b0;
      else if (do_push && (cnt_after_pop == CNT_W'(i)))
        tag_d[i] = push_tag;
      else
        tag_d[i] = shifted;
    end
  end

  always_comb begin
    if (clr || flush)
      cnt_d = '0;
    else
      cnt_d = cnt_after_pop + CNT_W'(do_push);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q <= '0;
      cnt_q <= '0;
    end else if (q_en) begin
      tag_q <= tag_d;
      cnt_q <= cnt_d;
    end
  end

  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
  assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt_q == '0));
  assert_no_fire_on_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !pop_fire);
endmodule

// File: rtl/dbg_bkpt_reqctl.sv
module dbg_bkpt_reqctl (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic access_hit,
  input  logic boundary,
  input  logic tag_fire,
  input  logic ack,
  output logic req
);
  logic pend_q, pend_d, req_q, req_d, st_en;

  always_comb begin
    pend_d = pend_q;
    req_d  = req_q;
    if (!enable || ack) begin
      pend_d = 1'b0;
      req_d  = 1'b0;
    end else begin
      if (access_hit)
        pend_d = 1'b1;
      if ((boundary && pend_q) || tag_fire)
        req_d = 1'b1;
    end
    st_en = (pend_d != pend_q) || (req_d != req_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      req_q  <= 1'b0;
    end else if (st_en) begin
      pend_q <= pend_d;
      req_q  <= req_d;
    end
  end

  assign req = req_q && enable;

  assert_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !req);
  assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !req_q && !pend_q);
  assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && enable && !ack) |=> req_q);
  assert_rise_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_q) |-> $past(tag_fire || (boundary && pend_q)));
endmodule

// File: rtl/dbg_bkpt_unit.sv
module dbg_bkpt_unit #(
  parameter int ADDR_W = 16,
  parameter int QDEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_match,
  input  logic              cfg_enable,
  input  logic              cfg_force_sel,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_valid,
  input  logic              insn_boundary,
  input  logic              fetch_push,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              exec_pop,
  input  logic              q_flush,
  input  logic              dbg_access,
  input  logic              bkpt_ack,
  output logic              bkpt_req
);
  import dbg_bkpt_pkg::*;

  bkpt_kind_e kind;
  logic access_hit, fetch_hit, tag_fire, forced_ok, tagged_ok;

  always_comb begin
    kind      = bkpt_kind_e'(cfg_force_sel);
    forced_ok = cfg_enable && (kind == KIND_FORCED);
    tagged_ok = cfg_enable && (kind == KIND_TAGGED);
  end

  dbg_bkpt_cmp #(.ADDR_W(ADDR_W)) u_cmp_access (
    .match_val(cfg_match), .addr(bus_addr), .strobe(bus_valid),
    .kind_ok(forced_ok), .suppress(dbg_access), .hit(access_hit));

  dbg_bkpt_cmp #(.ADDR_W(ADDR_W)) u_cmp_fetch (
    .match_val(cfg_match), .addr(fetch_addr), .strobe(fetch_push),
    .kind_ok(tagged_ok), .suppress(dbg_access), .hit(fetch_hit));

  dbg_bkpt_tagq #(.DEPTH(QDEPTH)) u_tagq (
    .clk(clk), .rst_n(rst_n), .clr(!cfg_enable), .push(fetch_push),
    .push_tag(fetch_hit), .pop(exec_pop), .flush(q_flush), .pop_fire(tag_fire));

  dbg_bkpt_reqctl u_req (
    .clk(clk), .rst_n(rst_n), .enable(cfg_enable), .access_hit(access_hit),
    .boundary(insn_boundary), .tag_fire(tag_fire), .ack(bkpt_ack), .req(bkpt_req));

  assert_suppress_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_access |-> !access_hit && !fetch_hit);
  assert_kind_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(access_hit && fetch_hit && (bus_addr == fetch_addr)));
endmodule

// File: tb/dbg_bkpt_unit_bench.sv
module dbg_bkpt_unit_bench;
  localparam int AW = 16;
  localparam int QD = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] cfg_match, bus_addr, fetch_addr;
  logic cfg_enable, cfg_force_sel, bus_valid, insn_boundary, fetch_push;
  logic exec_pop, q_flush, dbg_access, bkpt_ack, bkpt_req;

  int n_chk = 0, n_bad = 0;
  logic m_pend, m_req;
  logic m_q [QD];
  int   m_cnt;

  always #10 clk = ~clk;

  dbg_bkpt_unit #(.ADDR_W(AW), .QDEPTH(QD)) u_dbg_bkpt_unit (
    .clk, .rst_n, .cfg_match, .cfg_enable, .cfg_force_sel, .bus_addr, .bus_valid,
    .insn_boundary, .fetch_push, .fetch_addr, .exec_pop, .q_flush, .dbg_access,
    .bkpt_ack, .bkpt_req);

  function automatic logic exp_req();
    return m_req && cfg_enable;
  endfunction

  task automatic model_reset();
    m_pend = 0; m_req = 0; m_cnt = 0;
    for (int i = 0; i < QD; i++) m_q[i] = 0;
  endtask

  task automatic model_step();
    logic hit_a, tag_in, pfire;
    int after;
    hit_a  = bus_valid && bus_addr == cfg_match && cfg_force_sel && !dbg_access;
    tag_in = fetch_addr == cfg_match && !cfg_force_sel && !dbg_access;
    pfire  = exec_pop && !q_flush && m_cnt > 0 && m_q[0];
    if (!cfg_enable || bkpt_ack) begin
      m_pend = 0; m_req = 0;
    end else begin
      if (insn_boundary && m_pend) m_req = 1;
      if (pfire) m_req = 1;
      if (hit_a) m_pend = 1;
    end
    if (!cfg_enable || q_flush) begin
      m_cnt = 0;
      for (int i = 0; i < QD; i++) m_q[i] = 0;
    end else begin
      if (exec_pop && m_cnt > 0) begin
        for (int i = 0; i < QD - 1; i++) m_q[i] = m_q[i+1];
        m_q[QD-1] = 0;
        m_cnt--;
      end
      after = m_cnt;
      if (fetch_push && after < QD) begin
        m_q[after] = tag_in;
        m_cnt++;
      end
    end
  endtask

  task automatic check(input string req, input logic exp);
    n_chk++;
    if (bkpt_req !== exp) begin
      n_bad++;
      $display("FAIL %s: bkpt_req=%b expected %b", req, bkpt_req, exp);
    end
  endtask

  task automatic idle();
    bus_valid = 0; insn_boundary = 0; fetch_push = 0; exec_pop = 0;
    q_flush = 0; dbg_access = 0; bkpt_ack = 0;
    bus_addr = '0; fetch_addr = '0;
  endtask

  task automatic step(input string req);
    @(posedge clk);
    model_step();
    @(negedge clk);
    check(req, exp_req());
    idle();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not end, actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'h5eed_1234));
    idle();
    cfg_match = 16'h4A10; cfg_enable = 0; cfg_force_sel = 1;
    model_reset();
    repeat (3) @(negedge clk);
    check("R1", 1'b0);
    rst_n = 1;
    @(negedge clk);
    check("R1", 1'b0);
    cfg_enable = 1;

    // R3: same-cycle boundary does not fire, later one does
    bus_valid = 1; bus_addr = 16'h4A10; insn_boundary = 1; step("R3");
    check("R3", 1'b0);
    step("R3");
    insn_boundary = 1; step("R3");
    check("R3", 1'b1);
    step("R11");                      // R11 held
    bkpt_ack = 1; step("R9");
    check("R9", 1'b0);
    insn_boundary = 1; step("R9");    // flag cleared by ack
    check("R9", 1'b0);

    // R4: invalid strobe / wrong address
    bus_valid = 0; bus_addr = 16'h4A10; step("R4");
    bus_valid = 1; bus_addr = 16'h4A11; step("R4");
    insn_boundary = 1; step("R4");
    check("R4", 1'b0);

    // R8: debug access suppresses
    bus_valid = 1; bus_addr = 16'h4A10; dbg_access = 1; step("R8");
    insn_boundary = 1; step("R8");
    check("R8", 1'b0);

    // R9: ack beats same-cycle access
    bus_valid = 1; bus_addr = 16'h4A10; bkpt_ack = 1; step("R9");
    insn_boundary = 1; step("R9");
    check("R9", 1'b0);

    // R10: access in tagged mode ignored; fetch in forced mode unmarked
    cfg_force_sel = 0;
    bus_valid = 1; bus_addr = 16'h4A10; step("R10");
    insn_boundary = 1; step("R10");
    check("R10", 1'b0);
    cfg_force_sel = 1;
    fetch_push = 1; fetch_addr = 16'h4A10; step("R10");
    cfg_force_sel = 0;
    exec_pop = 1; step("R10");
    check("R10", 1'b0);

    // R5/R6: marked entry at position 3 fires on third pop
    fetch_push = 1; fetch_addr = 16'h0001; step("R6");
    fetch_push = 1; fetch_addr = 16'h0002; step("R6");
    fetch_push = 1; fetch_addr = 16'h4A10; step("R5");
    exec_pop = 1; step("R6");
    check("R6", 1'b0);
    exec_pop = 1; step("R6");
    check("R6", 1'b0);
    exec_pop = 1; step("R5");
    check("R5", 1'b1);
    bkpt_ack = 1; step("R9");
    exec_pop = 1; step("R5");         // empty pop
    check("R5", 1'b0);

    // R6: push into full queue dropped
    for (int i = 0; i < QD; i++) begin
      fetch_push = 1; fetch_addr = 16'h0100 + 16'(i); step("R6");
    end
    fetch_push = 1; fetch_addr = 16'h4A10; step("R6");
    for (int i = 0; i <= QD; i++) begin
      exec_pop = 1; step("R6");
    end
    check("R6", 1'b0);

    // R7: flush discards mark, flush beats pop
    fetch_push = 1; fetch_addr = 16'h4A10; step("R7");
    exec_pop = 1; q_flush = 1; step("R7");
    check("R7", 1'b0);
    exec_pop = 1; step("R7");
    check("R7", 1'b0);

    // R2: disable clears pending and masks output
    cfg_force_sel = 1;
    bus_valid = 1; bus_addr = 16'h4A10; step("R2");
    insn_boundary = 1; step("R2");
    check("R2", 1'b1);
    cfg_enable = 0;
    #1 check("R2", 1'b0);
    step("R2");
    cfg_enable = 1;
    insn_boundary = 1; step("R2");
    check("R2", 1'b0);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      cfg_enable    = ($urandom % 40) != 0;
      if (($urandom % 50) == 0) cfg_force_sel = ~cfg_force_sel;
      bus_valid     = $urandom % 2;
      bus_addr      = ($urandom % 3 == 0) ? cfg_match : 16'($urandom);
      insn_boundary = ($urandom % 4) == 0;
      fetch_push    = ($urandom % 2);
      fetch_addr    = ($urandom % 3 == 0) ? cfg_match : 16'($urandom);
      exec_pop      = ($urandom % 2);
      q_flush       = ($urandom % 25) == 0;
      dbg_access    = ($urandom % 12) == 0;
      bkpt_ack      = ($urandom % 6) == 0;
      step("R3 R5 R11 random");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule